// File: doc/BRIEF.md
# System Control Register Block

This block is a memory-mapped bank of general-purpose 32-bit control words for a chip-level system controller. It sits on a plain word-wide register bus that carries an address, a write strobe, a read strobe, write data and registered read data. The bank stores 512 words at the bottom of a 4 KB window. A few words come out of reset holding fixed identification and configuration values, and three of them always read back with two status bits set.

The window also has a command word that lies above the storage bank. When software writes a command code there, the block emits a one-cycle request to an external reset and power controller. The request is either a system reset or a shutdown. Any access that falls outside the storage bank gives a one-cycle error pulse that a bus monitor can count or log. That access does not stall the bus.

Top module: `sysctl_regs`

## Requirements
- R1: While `rst_n` is low, every output is 0. After reset, word index 0x40 (byte 0x100) holds 0x05F20121, index 0x41 (byte 0x104) holds 0x00000002, index 0x42 (byte 0x108) holds 0x05F30121, index 0x43 (byte 0x10C) holds 0x05F40121, and every other word holds 0.
- R2: A write with `bus_wr` high at a byte offset below 0x800 stores `bus_wdata` into word offset/4. A read with `bus_rd` high places that word on `bus_rdata` on the next clock edge. `bus_rdata` keeps its value in cycles without a read. Address bits [1:0] are ignored. The block assumes that `bus_wr` and `bus_rd` are never high together.
- R3: A read at byte offset 0x100, 0x108 or 0x10C returns the stored word ORed with 0x30000000. A read at 0x104 or at any other offset returns the stored word unchanged. The forcing acts only on the read path, so every other bit returns exactly what was last written.
- R4: A write at byte offset 0xF00 with data 1 or 2 drives `sys_reset_req` high for the single following cycle. The same write with data 3 drives `sys_off_req` high for the single following cycle. Any other data value raises neither output.
- R5: A command write at 0xF00 stores nothing. In particular, word index 0x1C0 (byte 0x700) is left unchanged by it.
- R6: A write at a byte offset of 0x800 or above changes no stored word and does not wrap onto a lower word. A read there returns 0.
- R7: Any read or write at a byte offset of 0x800 or above drives `bus_err` high for the single following cycle. This includes command writes. Accesses below 0x800 never raise it.
- R8: The error pulse and the request pulses do not hold up the bus. An access in the cycle right after an erroring access completes normally and raises no error of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte offset within the 4 KB window |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read |
| sys_reset_req | output | 1 | One-cycle system reset request |
| sys_off_req | output | 1 | One-cycle shutdown request |
| bus_err | output | 1 | One-cycle pulse after an access outside the storage bank |

## Verification
The assertions assume that the bus never asserts a read and a write in the same cycle. One property checks this directly, and the source checks for the pulses and for read data rely on each cycle carrying at most one access. The bench drives every access from a task that raises exactly one strobe for one cycle and clears it before the next access. Stimulus covers command codes, overlay offsets and out-of-range offsets, including the word that the command offset would alias to and a write above the bank that would wrap onto a forced word.

// File: rtl/sysctl_pkg.sv
// Shared constants and helper functions for the system control register block.
// Assumes a 32-bit data path. The reset table and read-overlay set are
// expressed as word indices into the storage bank.
package sysctl_pkg;

    localparam int unsigned SC_DATA_W = 32;

    // Bits forced high on overlay words during reads.
    localparam logic [SC_DATA_W-1:0] SC_FORCE_MASK = 32'h3000_0000;

    // Command codes accepted at the command offset.
    localparam logic [SC_DATA_W-1:0] SC_CMD_RST_A = 32'd1;
    localparam logic [SC_DATA_W-1:0] SC_CMD_RST_B = 32'd2;
    localparam logic [SC_DATA_W-1:0] SC_CMD_OFF   = 32'd3;

    // Reset value of a storage word, by word index.
    function automatic logic [SC_DATA_W-1:0] sc_reset_word(input int unsigned idx);
        case (idx)
            32'h40:  return 32'h05F2_0121;
            32'h41:  return 32'h0000_0002;
            32'h42:  return 32'h05F3_0121;
            32'h43:  return 32'h05F4_0121;
            default: return '0;
        endcase
    endfunction

    // True for word indices whose read value carries the forced bits.
    function automatic logic sc_is_forced(input int unsigned idx);
        return (idx == 32'h40) || (idx == 32'h42) || (idx == 32'h43);
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
// Address decoder: turns a word address into a storage hit, a command hit
// and a storage index. Assumes the caller has already dropped the byte-lane
// bits, so every access is a full word.
module sysctl_decode #(
    parameter int unsigned WA_W    = 10,
    parameter int unsigned DEPTH   = 512,
    parameter logic [WA_W-1:0] CMD_WA = 10'h3C0,
    localparam int unsigned IDX_W  = $clog2(DEPTH)
) (
    input  logic [WA_W-1:0]  word_addr,
    output logic             in_range,
    output logic             is_cmd,
    output logic [IDX_W-1:0] idx
);

    // Classify the word address against the bank size and command word.
    always_comb begin
        in_range = (32'(word_addr) < 32'(DEPTH));
        is_cmd   = (word_addr == CMD_WA);
        idx      = word_addr[IDX_W-1:0];
    end

endmodule

// File: rtl/sysctl_store.sv
// Storage bank with per-word reset values and a registered read port.
// Assumes at most one of write or read per cycle. The read path ORs the
// forced bits into overlay words; stored contents are never altered by it.
module sysctl_store
    import sysctl_pkg::*;
#(
    parameter int unsigned DEPTH = 512,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic                 in_range,
    input  logic [IDX_W-1:0]     idx,
    input  logic [SC_DATA_W-1:0] wdata,
    output logic [SC_DATA_W-1:0] rdata
);

    logic [SC_DATA_W-1:0] words [DEPTH];
    logic [SC_DATA_W-1:0] rd_word;

    // One register per word, loaded with its own reset value.
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        // Update word g on a write that selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[g] <= sc_reset_word(g);
            end else if (wr_en && (idx == IDX_W'(g))) begin
                words[g] <= wdata;
            end
        end
    end

    // Select the addressed word and apply the read overlay.
    always_comb begin
        rd_word = words[idx];
        if (sc_is_forced(32'(idx))) begin
            rd_word = rd_word | SC_FORCE_MASK;
        end
    end

    // Register read data; out-of-bank reads return zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= in_range ? rd_word : '0;
        end
    end

endmodule

// File: rtl/sysctl_cmd.sv
// Command and error pulse generator. Assumes the decoder flags command and
// range hits for the current cycle. Produces registered one-cycle pulses.
module sysctl_cmd
    import sysctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic                 is_cmd,
    input  logic                 in_range,
    input  logic [SC_DATA_W-1:0] wdata,
    output logic                 reset_req,
    output logic                 off_req,
    output logic                 err
);

    logic cmd_wr;
    logic want_rst;
    logic want_off;

    // Decode the command code of a write to the command word.
    always_comb begin
        cmd_wr   = bus_wr && is_cmd;
        want_rst = cmd_wr && ((wdata == SC_CMD_RST_A) || (wdata == SC_CMD_RST_B));
        want_off = cmd_wr && (wdata == SC_CMD_OFF);
    end

    // Register the request and error pulses for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_req <= 1'b0;
            off_req   <= 1'b0;
            err       <= 1'b0;
        end else begin
            reset_req <= want_rst;
            off_req   <= want_off;
            err       <= (bus_wr || bus_rd) && !in_range;
        end
    end

endmodule

// File: rtl/sysctl_regs.sv
// System control register block top. Joins the decoder, the storage bank
// and the command pulse generator. Assumes a bus that issues at most one
// read or write per cycle; byte-lane bits of the address are ignored.
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DEPTH  = 512,
    parameter logic [ADDR_W-1:0] CMD_OFFSET = 12'hF00,
    localparam int unsigned WA_W  = ADDR_W - 2,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [SC_DATA_W-1:0] bus_wdata,
    output logic [SC_DATA_W-1:0] bus_rdata,
    output logic                 sys_reset_req,
    output logic                 sys_off_req,
    output logic                 bus_err
);

    logic             hit_store;
    logic             hit_cmd;
    logic [IDX_W-1:0] word_idx;
    logic             byte_lane_unused;

    // Byte-lane bits carry no meaning for full-word accesses.
    assign byte_lane_unused = ^bus_addr[1:0];

    sysctl_decode #(
        .WA_W  (WA_W),
        .DEPTH (DEPTH),
        .CMD_WA(CMD_OFFSET[ADDR_W-1:2])
    ) u_decode (
        .word_addr(bus_addr[ADDR_W-1:2]),
        .in_range (hit_store),
        .is_cmd   (hit_cmd),
        .idx      (word_idx)
    );

    sysctl_store #(
        .DEPTH(DEPTH)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr && hit_store),
        .rd_en   (bus_rd),
        .in_range(hit_store),
        .idx     (word_idx),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata)
    );

    sysctl_cmd u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .is_cmd   (hit_cmd),
        .in_range (hit_store),
        .wdata    (bus_wdata),
        .reset_req(sys_reset_req),
        .off_req  (sys_off_req),
        .err      (bus_err)
    );

endmodule

// File: rtl/sysctl_regs_chk.sv
// Property checker for the system control register block, bound to the top.
// Works from the top-level ports only.
module sysctl_regs_chk #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DEPTH  = 512,
    parameter logic [ADDR_W-1:0] CMD_OFFSET = 12'hF00
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              sys_reset_req,
    input logic              sys_off_req,
    input logic              bus_err
);

    logic oob;
    logic at_cmd;
    logic at_overlay;

    // Port-level view of the address.
    always_comb begin
        oob        = (32'(bus_addr[ADDR_W-1:2]) >= 32'(DEPTH));
        at_cmd     = (bus_addr[ADDR_W-1:2] == CMD_OFFSET[ADDR_W-1:2]);
        at_overlay = (bus_addr[ADDR_W-1:2] == 10'h40) ||
                     (bus_addr[ADDR_W-1:2] == 10'h42) ||
                     (bus_addr[ADDR_W-1:2] == 10'h43);
    end

    // R2: bus never overlaps read and write.
    a_r2_no_collision: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));

    // R2: read data holds when no read was issued.
    a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!bus_rd) |-> $stable(bus_rdata));

    // R3: overlay reads carry the forced bits.
    a_r3_forced_bits: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && at_overlay) |-> (bus_rdata[29:28] == 2'b11));

    // R4: reset request only follows a reset command.
    a_r4_reset_src: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> $past(bus_wr && at_cmd && ((bus_wdata == 32'd1) || (bus_wdata == 32'd2))));

    // R4: shutdown command always yields a shutdown request.
    a_r4_off_fire: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_wr && at_cmd && (bus_wdata == 32'd3)) |-> (sys_off_req && !sys_reset_req));

    // R4: shutdown request only follows a shutdown command.
    a_r4_off_src: assert property (@(posedge clk) disable iff (!rst_n)
        sys_off_req |-> $past(bus_wr && at_cmd && (bus_wdata == 32'd3)));

    // R6: reads above the bank return zero.
    a_r6_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && oob) |-> (bus_rdata == 32'd0));

    // R7: error pulse follows exactly the out-of-bank accesses.
    a_r7_err_src: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past((bus_wr || bus_rd) && oob));

    // R7: every out-of-bank access raises the error pulse.
    a_r7_err_fire: assert property (@(posedge clk) disable iff (!rst_n)
        $past((bus_wr || bus_rd) && oob) |-> bus_err);

endmodule

bind sysctl_regs sysctl_regs_chk #(
    .ADDR_W    (ADDR_W),
    .DEPTH     (DEPTH),
    .CMD_OFFSET(CMD_OFFSET)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .sys_reset_req(sys_reset_req),
    .sys_off_req  (sys_off_req),
    .bus_err      (bus_err)
);

// File: tb/sysctl_regs_bench.sv
// Directed bench for the system control register block.
module sysctl_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sys_reset_req;
    logic        sys_off_req;
    logic        bus_err;

    int checks = 0;
    int errors = 0;

    // Captured outputs from the cycle after the last access.
    logic [31:0] cap_rdata;
    logic        cap_rst, cap_off, cap_err;

    always #10 clk = ~clk;

    sysctl_regs u_sysctl_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .sys_reset_req(sys_reset_req),
        .sys_off_req  (sys_off_req),
        .bus_err      (bus_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic capture();
        cap_rdata = bus_rdata;
        cap_rst   = sys_reset_req;
        cap_off   = sys_off_req;
        cap_err   = bus_err;
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        capture();
    endtask

    task automatic do_read(input logic [11:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        capture();
    endtask

    task automatic expect_read(input logic [11:0] a, input logic [31:0] exp, input string req);
        do_read(a);
        check(cap_rdata == exp, req, $sformatf("read 0x%03h", a), cap_rdata, exp);
        check(cap_err == 1'b0, req, "no error on in-bank read", 32'(cap_err), 32'd0);
    endtask

    task automatic t_reset_state();
        check(bus_rdata == 0 && !sys_reset_req && !sys_off_req && !bus_err,
              "R1", "outputs in reset", {bus_rdata[28:0], sys_reset_req, sys_off_req, bus_err}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        expect_read(12'h100, 32'h35F2_0121, "R1");
        expect_read(12'h104, 32'h0000_0002, "R1");
        expect_read(12'h108, 32'h35F3_0121, "R1");
        expect_read(12'h10C, 32'h35F4_0121, "R1");
        expect_read(12'h000, 32'h0, "R1");
        expect_read(12'h0FC, 32'h0, "R1");
        expect_read(12'h7FC, 32'h0, "R1");
    endtask

    task automatic t_rw_basic();
        do_write(12'h010, 32'hA5A5_1234);
        check(!cap_err && !cap_rst && !cap_off, "R2", "write side effects", {cap_err, cap_rst, cap_off}, 0);
        expect_read(12'h010, 32'hA5A5_1234, "R2");
        do_write(12'h203, 32'h0BAD_F00D);
        expect_read(12'h200, 32'h0BAD_F00D, "R2");
        expect_read(12'h201, 32'h0BAD_F00D, "R2");
        do_write(12'h7FC, 32'hFFFF_FFFF);
        expect_read(12'h7FC, 32'hFFFF_FFFF, "R2");
        repeat (3) @(negedge clk);
        check(bus_rdata == 32'hFFFF_FFFF, "R2", "rdata holds without read", bus_rdata, 32'hFFFF_FFFF);
    endtask

    task automatic t_forced_bits();
        do_write(12'h100, 32'h0);
        expect_read(12'h100, 32'h3000_0000, "R3");
        do_write(12'h104, 32'h0);
        expect_read(12'h104, 32'h0, "R3");
        do_write(12'h10C, 32'h0000_ABCD);
        expect_read(12'h10C, 32'h3000_ABCD, "R3");
        do_write(12'h108, 32'hCFFF_FFFF);
        expect_read(12'h108, 32'hFFFF_FFFF, "R3");
        do_write(12'h110, 32'h0);
        expect_read(12'h110, 32'h0, "R3");
    endtask

    task automatic cmd_case(input logic [11:0] a, input logic [31:0] d,
                            input bit exp_rst, input bit exp_off);
        do_write(a, d);
        check(cap_rst == exp_rst, "R4", $sformatf("reset req for 0x%0h", d), 32'(cap_rst), 32'(exp_rst));
        check(cap_off == exp_off, "R4", $sformatf("off req for 0x%0h", d), 32'(cap_off), 32'(exp_off));
        check(cap_err == 1'b1, "R7", "error on command write", 32'(cap_err), 32'd1);
        @(negedge clk);
        check(!sys_reset_req && !sys_off_req && !bus_err, "R4", "pulses last one cycle",
              {sys_reset_req, sys_off_req, bus_err}, 32'd0);
    endtask

    task automatic t_commands();
        cmd_case(12'hF00, 32'd1, 1'b1, 1'b0);
        cmd_case(12'hF00, 32'd2, 1'b1, 1'b0);
        cmd_case(12'hF00, 32'd3, 1'b0, 1'b1);
        cmd_case(12'hF02, 32'd3, 1'b0, 1'b1);
        cmd_case(12'hF00, 32'd0, 1'b0, 1'b0);
        cmd_case(12'hF00, 32'd4, 1'b0, 1'b0);
        cmd_case(12'hF00, 32'hFFFF_FFFF, 1'b0, 1'b0);
        cmd_case(12'hF04, 32'd1, 1'b0, 1'b0);
    endtask

    task automatic t_cmd_no_store();
        do_write(12'h700, 32'h1234_5678);
        do_write(12'hF00, 32'd3);
        expect_read(12'h700, 32'h1234_5678, "R5");
        do_write(12'hF00, 32'h0000_0000);
        expect_read(12'h700, 32'h1234_5678, "R5");
    endtask

    task automatic t_out_of_range();
        do_write(12'h100, 32'h0000_0055);
        do_write(12'h900, 32'hDEAD_BEEF);
        check(cap_err == 1'b1, "R7", "error on high write", 32'(cap_err), 32'd1);
        expect_read(12'h100, 32'h3000_0055, "R6");
        do_write(12'h800, 32'hCAFE_0001);
        expect_read(12'h000, 32'h0, "R6");
        do_read(12'h900);
        check(cap_rdata == 32'h0, "R6", "high read value", cap_rdata, 32'h0);
        check(cap_err == 1'b1, "R7", "error on high read", 32'(cap_err), 32'd1);
        do_read(12'hFFC);
        check(cap_rdata == 32'h0, "R6", "top read value", cap_rdata, 32'h0);
        check(cap_err == 1'b1, "R7", "error on top read", 32'(cap_err), 32'd1);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        bus_addr = 12'hA00; bus_wdata = 32'h1111_1111; bus_wr = 1'b1;
        @(negedge clk);
        check(bus_err == 1'b1, "R8", "first access errors", 32'(bus_err), 32'd1);
        bus_addr = 12'h020; bus_wdata = 32'h2222_2222;
        @(negedge clk);
        check(bus_err == 1'b0, "R8", "following access clean", 32'(bus_err), 32'd0);
        bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = 12'hB00;
        @(negedge clk);
        bus_addr = 12'h020;
        check(bus_err == 1'b1, "R8", "read error pulse", 32'(bus_err), 32'd1);
        @(negedge clk);
        bus_rd = 1'b0;
        check(bus_err == 1'b0, "R8", "read after error clean", 32'(bus_err), 32'd0);
        check(bus_rdata == 32'h2222_2222, "R8", "read after error data", bus_rdata, 32'h2222_2222);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        t_reset_state();
        t_rw_basic();
        t_forced_bits();
        t_commands();
        t_cmd_no_store();
        t_out_of_range();
        t_back_to_back();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule